// File: doc/BRIEF.md
# Instruction-Decoded Three-Bus Register File

This block holds eight 32-bit general-purpose registers. Two read buses (B1, B2) and one write bus (B3) connect them to the datapath. The block does not take register numbers from a sequencer. It derives all three 3-bit register selectors straight from the 32-bit instruction word. The write selector and the B2 selector come from fixed instruction fields. The B1 selector takes one field for the store-register opcode and a different field for every other opcode.

The control sequencer supplies a read strobe for each source bus and a write strobe for the destination bus. When its strobe is low, a read bus drives all zeros, so the buses can be combined with OR gates instead of tri-state drivers. Register 0 is a constant zero. Writes to register 0 are discarded, which lets a zero index field stand for "no index register".

Writes commit on the rising clock edge. Reads are combinational, so a read in the same cycle as a write returns the value held before that edge.

Top module: `three_bus_regfile`

## Requirements
- R1: The destination register written from B3 is selected by instruction bits 25:23 for every opcode.
- R2: The register driven onto B2 is selected by instruction bits 22:20 for every opcode.
- R3: For every opcode other than 5'b01101 in bits 31:27, the register driven onto B1 is selected by instruction bits 19:17.
- R4: When bits 31:27 equal 5'b01101 (store register), the register driven onto B1 is selected by instruction bits 25:23.
- R5: A read bus whose read strobe is low drives 32'h0, whatever the selector is.
- R6: Register 0 reads as 32'h0 on either bus, and a write strobe aimed at register 0 leaves it at zero.
- R7: A write takes effect at the rising clock edge. A read of the same register in the cycle of the write returns the old value, and the next cycle returns the new value.
- R8: While rst_n is low at a rising edge, every register is cleared to zero, and a write strobe in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Current instruction word |
| b1_rd_en | input | 1 | Read strobe for bus B1 |
| b2_rd_en | input | 1 | Read strobe for bus B2 |
| b3_wr_en | input | 1 | Write strobe for bus B3 |
| b3_data | input | 32 | Data to be written from bus B3 |
| b1_data | output | 32 | Bus B1 read data, zero when not strobed |
| b2_data | output | 32 | Bus B2 read data, zero when not strobed |

## Verification
The bench builds the block with its default parameters: 32-bit data, 3-bit selectors (eight registers) and the store opcode at 5'b01101. With these values, all eight register indices and all 32 opcodes can be reached exhaustively. A sweep of every opcode with different values in fields 25:23 and 19:17 shows that only the store opcode switches the B1 source. The test data is chosen so that every field could point at a register holding a distinct value, which means a wrong field choice always shows up as a wrong data word.

// File: rtl/regfile_pkg.sv
// Package: shared constants for the instruction-decoded register file.
// Assumes a 32-bit instruction with the opcode in its top five bits.
package regfile_pkg;

    // Instruction geometry
    localparam int INSTR_W_DEF  = 32;
    localparam int OPC_W        = 5;
    localparam int OPC_LSB_DEF  = 27;

    // Register-number fields inside the instruction
    localparam int DST_LSB_DEF  = 23;   // destination / store-source field
    localparam int IDX_LSB_DEF  = 20;   // second-source / index field
    localparam int SRC1_LSB_DEF = 17;   // first-source field

    // Opcode that reads its data source from the destination field
    localparam logic [OPC_W-1:0] STORE_OPC_DEF = 5'b01101;

    // Which field feeds the B1 selector
    typedef enum logic {
        B1_FROM_SRC1 = 1'b0,
        B1_FROM_DST  = 1'b1
    } b1_src_e;

endpackage

// File: rtl/sel_decode.sv
// Module: sel_decode
// Derives the three register selectors from the instruction word.
// Assumes the three fields do not overlap the opcode; the B1 selector
// switches to the destination field for the store opcode only.
module sel_decode
    import regfile_pkg::*;
#(
    parameter int               INSTR_W   = INSTR_W_DEF,
    parameter int               SEL_W     = 3,
    parameter int               OPC_LSB   = OPC_LSB_DEF,
    parameter int               DST_LSB   = DST_LSB_DEF,
    parameter int               IDX_LSB   = IDX_LSB_DEF,
    parameter int               SRC1_LSB  = SRC1_LSB_DEF,
    parameter logic [OPC_W-1:0] STORE_OPC = STORE_OPC_DEF
) (
    input  logic [INSTR_W-1:0] instr,
    output logic [SEL_W-1:0]   b1_sel,
    output logic [SEL_W-1:0]   b2_sel,
    output logic [SEL_W-1:0]   b3_sel
);

    logic [OPC_W-1:0] opcode;
    logic [SEL_W-1:0] dst_field;
    logic [SEL_W-1:0] idx_field;
    logic [SEL_W-1:0] src1_field;
    b1_src_e          b1_src;

    // Slice the opcode and the three register fields
    always_comb begin
        opcode     = instr[OPC_LSB +: OPC_W];
        dst_field  = instr[DST_LSB +: SEL_W];
        idx_field  = instr[IDX_LSB +: SEL_W];
        src1_field = instr[SRC1_LSB +: SEL_W];
    end

    // Choose the B1 source field from the opcode
    always_comb begin
        b1_src = (opcode == STORE_OPC) ? B1_FROM_DST : B1_FROM_SRC1;
    end

    // Drive the selectors
    always_comb begin
        b3_sel = dst_field;
        b2_sel = idx_field;
        unique case (b1_src)
            B1_FROM_DST:  b1_sel = dst_field;
            default:      b1_sel = src1_field;
        endcase
    end

endmodule

// File: rtl/reg_store.sv
// Module: reg_store
// Register storage with one synchronous write port.
// Entry 0 has no storage and reads as zero; a synchronous active-low
// reset clears every stored entry and takes priority over a write.
module reg_store #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3,
    localparam int NUM_REGS = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] regs [NUM_REGS]
);

    logic [NUM_REGS-1:0] wr_hit;

    // One-hot write decode
    always_comb begin
        wr_hit = '0;
        if (wr_en) wr_hit[wr_sel] = 1'b1;
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_entry
        if (gi == 0) begin : g_zero
            // Hardwired zero entry
            assign regs[gi] = '0;
        end else begin : g_word
            logic [DATA_W-1:0] word_q;

            // Reset or capture this entry's word
            always_ff @(posedge clk) begin
                if (!rst_n)          word_q <= '0;
                else if (wr_hit[gi]) word_q <= wr_data;
            end

            assign regs[gi] = word_q;
        end
    end

endmodule

// File: rtl/read_port.sv
// Module: read_port
// One combinational read bus: selects an entry and gates it with the
// strobe, so an idle bus drives zero and buses can be OR-combined.
module read_port #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3,
    localparam int NUM_REGS = 1 << SEL_W
) (
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [DATA_W-1:0] regs [NUM_REGS],
    output logic [DATA_W-1:0] rd_data
);

    // Select and gate
    always_comb begin
        rd_data = rd_en ? regs[rd_sel] : '0;
    end

endmodule

// File: rtl/three_bus_regfile.sv
// Module: three_bus_regfile (top)
// Eight-entry register file with two read buses and one write bus; the
// register selectors are decoded from the instruction word. Assumes the
// sequencer supplies the strobes and never writes during a store.
module three_bus_regfile
    import regfile_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter int               INSTR_W   = INSTR_W_DEF,
    parameter int               SEL_W     = 3,
    parameter int               OPC_LSB   = OPC_LSB_DEF,
    parameter int               DST_LSB   = DST_LSB_DEF,
    parameter int               IDX_LSB   = IDX_LSB_DEF,
    parameter int               SRC1_LSB  = SRC1_LSB_DEF,
    parameter logic [OPC_W-1:0] STORE_OPC = STORE_OPC_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               b1_rd_en,
    input  logic               b2_rd_en,
    input  logic               b3_wr_en,
    input  logic [DATA_W-1:0]  b3_data,
    output logic [DATA_W-1:0]  b1_data,
    output logic [DATA_W-1:0]  b2_data
);

    localparam int NUM_REGS = 1 << SEL_W;
    localparam int NUM_RD   = 2;

    logic [SEL_W-1:0]  b1_sel, b2_sel, b3_sel;
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [SEL_W-1:0]  rd_sel  [NUM_RD];
    logic              rd_en   [NUM_RD];
    logic [DATA_W-1:0] rd_data [NUM_RD];

    sel_decode #(
        .INSTR_W  (INSTR_W),
        .SEL_W    (SEL_W),
        .OPC_LSB  (OPC_LSB),
        .DST_LSB  (DST_LSB),
        .IDX_LSB  (IDX_LSB),
        .SRC1_LSB (SRC1_LSB),
        .STORE_OPC(STORE_OPC)
    ) u_dec (
        .instr (instr),
        .b1_sel(b1_sel),
        .b2_sel(b2_sel),
        .b3_sel(b3_sel)
    );

    reg_store #(
        .DATA_W(DATA_W),
        .SEL_W (SEL_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (b3_wr_en),
        .wr_sel (b3_sel),
        .wr_data(b3_data),
        .regs   (regs)
    );

    // Gather per-bus selector and strobe
    always_comb begin
        rd_sel[0] = b1_sel;
        rd_sel[1] = b2_sel;
        rd_en[0]  = b1_rd_en;
        rd_en[1]  = b2_rd_en;
    end

    for (genvar gp = 0; gp < NUM_RD; gp++) begin : g_port
        read_port #(
            .DATA_W(DATA_W),
            .SEL_W (SEL_W)
        ) u_rd (
            .rd_en  (rd_en[gp]),
            .rd_sel (rd_sel[gp]),
            .regs   (regs),
            .rd_data(rd_data[gp])
        );
    end

    // Drive the output buses
    always_comb begin
        b1_data = rd_data[0];
        b2_data = rd_data[1];
    end

endmodule

// File: rtl/regfile_chk.sv
// Module: regfile_chk
// Port-level properties of three_bus_regfile, attached by bind.
// Assumes the default field layout (selectors in 25:23, 22:20, 19:17).
module regfile_chk #(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr,
    input logic               b1_rd_en,
    input logic               b2_rd_en,
    input logic               b3_wr_en,
    input logic [DATA_W-1:0]  b3_data,
    input logic [DATA_W-1:0]  b1_data,
    input logic [DATA_W-1:0]  b2_data
);

    logic       is_store;
    logic [2:0] b1_field;

    // Independent view of which field B1 should follow
    always_comb begin
        is_store = (instr[31:27] == 5'b01101);
        b1_field = is_store ? instr[25:23] : instr[19:17];
    end

    a_r5_b1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !b1_rd_en |-> b1_data == '0);

    a_r5_b2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !b2_rd_en |-> b2_data == '0);

    a_r6_b2_reg0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (b2_rd_en && instr[22:20] == 3'd0) |-> b2_data == '0);

    // R3 and R4: a zero in the field B1 follows gives zero data
    a_r6_b1_reg0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (b1_rd_en && b1_field == 3'd0) |-> b1_data == '0);

    // R1 with R2: last cycle's write is visible through B2 now
    a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b3_wr_en) && $past(instr[25:23]) != 3'd0
         && b2_rd_en && instr[22:20] == $past(instr[25:23]))
        |-> b2_data == $past(b3_data));

    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && b2_rd_en) |-> b2_data == '0);

    a_r7_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(b3_wr_en) && $stable(instr)
         && b2_rd_en && $past(b2_rd_en)) |-> $stable(b2_data));

endmodule

bind three_bus_regfile regfile_chk #(
    .DATA_W (DATA_W),
    .INSTR_W(INSTR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .instr   (instr),
    .b1_rd_en(b1_rd_en),
    .b2_rd_en(b2_rd_en),
    .b3_wr_en(b3_wr_en),
    .b3_data (b3_data),
    .b1_data (b1_data),
    .b2_data (b2_data)
);

// File: tb/tb_three_bus_regfile.sv
// Bench for three_bus_regfile: a vector table, then an opcode sweep and
// reset corner cases. Inputs change at the falling edge; outputs are
// sampled 2 ns later, before the next rising edge.
module tb_three_bus_regfile;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] OP_LDI = 5'b00001;
    localparam logic [4:0] OP_PUT = 5'b01001;
    localparam logic [4:0] OP_LDR = 5'b01100;
    localparam logic [4:0] OP_STR = 5'b01101;
    localparam logic [4:0] OP_ADD = 5'b10101;

    localparam logic [31:0] A1 = 32'h1111_0001;
    localparam logic [31:0] A2 = 32'hA5A5_0002;
    localparam logic [31:0] A3 = 32'h8000_0003;
    localparam logic [31:0] A4 = 32'h0000_00FF;
    localparam logic [31:0] A7 = 32'h7777_7777;
    localparam logic [31:0] JUNK = 32'hDEAD_BEEF;

    typedef struct packed {
        logic [4:0]  opc;
        logic [2:0]  fa;   // bits 25:23
        logic [2:0]  fb;   // bits 22:20
        logic [2:0]  fc;   // bits 19:17
        logic        e1;
        logic        e2;
        logic        we;
        logic [31:0] wd;
        logic [31:0] x1;
        logic [31:0] x2;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{OP_ADD, 3'd1, 3'd0, 3'd0, 1'b1, 1'b1, 1'b1, A1,   32'h0, 32'h0, 4'd6}, // R6 R1
        '{OP_ADD, 3'd2, 3'd1, 3'd1, 1'b1, 1'b1, 1'b1, A2,   A1,    A1,    4'd3}, // R3 R2
        '{OP_LDI, 3'd3, 3'd2, 3'd2, 1'b1, 1'b1, 1'b1, A3,   A2,    A2,    4'd1}, // R1
        '{OP_ADD, 3'd3, 3'd3, 3'd3, 1'b1, 1'b1, 1'b1, A4,   A3,    A3,    4'd7}, // R7 old value
        '{OP_ADD, 3'd5, 3'd3, 3'd2, 1'b1, 1'b1, 1'b0, 32'h0, A2,   A4,    4'd7}, // R7 new value
        '{OP_STR, 3'd1, 3'd2, 3'd3, 1'b1, 1'b1, 1'b0, 32'h0, A1,   A2,    4'd4}, // R4
        '{OP_STR, 3'd3, 3'd1, 3'd2, 1'b1, 1'b1, 1'b0, 32'h0, A4,   A1,    4'd4}, // R4
        '{OP_LDR, 3'd2, 3'd3, 3'd1, 1'b1, 1'b1, 1'b0, 32'h0, A1,   A4,    4'd3}, // R3
        '{OP_ADD, 3'd0, 3'd0, 3'd0, 1'b1, 1'b1, 1'b1, JUNK, 32'h0, 32'h0, 4'd6}, // R6 write r0
        '{OP_ADD, 3'd7, 3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 4'd6}, // R6 r0 still 0
        '{OP_ADD, 3'd1, 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd5}, // R5
        '{OP_ADD, 3'd7, 3'd1, 3'd2, 1'b1, 1'b0, 1'b1, A7,   A2,    32'h0, 4'd5}, // R5 B2 idle
        '{OP_PUT, 3'd0, 3'd7, 3'd7, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, A7,   4'd2}, // R2 R5
        '{OP_STR, 3'd7, 3'd0, 3'd1, 1'b1, 1'b1, 1'b0, 32'h0, A7,   32'h0, 4'd4}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic        b1_rd_en, b2_rd_en, b3_wr_en;
    logic [31:0] b3_data;
    logic [31:0] b1_data, b2_data;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    three_bus_regfile dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .instr   (instr),
        .b1_rd_en(b1_rd_en),
        .b2_rd_en(b2_rd_en),
        .b3_wr_en(b3_wr_en),
        .b3_data (b3_data),
        .b1_data (b1_data),
        .b2_data (b2_data)
    );

    task automatic drive(input logic [4:0] opc, input logic [2:0] fa,
                         input logic [2:0] fb, input logic [2:0] fc,
                         input logic e1, input logic e2, input logic we,
                         input logic [31:0] wd);
        @(negedge clk);
        instr    = {opc, 1'b0, fa, fb, fc, 17'h0ABCD};
        b1_rd_en = e1;
        b2_rd_en = e2;
        b3_wr_en = we;
        b3_data  = wd;
        #2;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; instr = '0; b1_rd_en = 1'b0; b2_rd_en = 1'b0;
        b3_wr_en = 1'b0; b3_data = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: every register reads zero after reset
        for (int i = 1; i < 8; i++) begin
            drive(OP_ADD, 3'd0, 3'(i), 3'(i), 1'b1, 1'b1, 1'b0, '0);
            check("R8", $sformatf("reset B1 reg%0d", i), b1_data, 32'h0);
            check("R8", $sformatf("reset B2 reg%0d", i), b2_data, 32'h0);
        end

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            drive(VECS[v].opc, VECS[v].fa, VECS[v].fb, VECS[v].fc,
                  VECS[v].e1, VECS[v].e2, VECS[v].we, VECS[v].wd);
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d B1", v), b1_data, VECS[v].x1);
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d B2", v), b2_data, VECS[v].x2);
        end

        // R3/R4 sweep: reg3=A4, reg2=A2, reg1=A1
        for (int op = 0; op < 32; op++) begin
            drive(5'(op), 3'd3, 3'd2, 3'd1, 1'b1, 1'b1, 1'b0, '0);
            if (5'(op) == OP_STR)
                check("R4", $sformatf("sweep op%0d B1", op), b1_data, A4);
            else
                check("R3", $sformatf("sweep op%0d B1", op), b1_data, A1);
            check("R2", $sformatf("sweep op%0d B2", op), b2_data, A2);
        end

        // R8: reset mid-run beats a simultaneous write to reg5
        @(negedge clk);
        rst_n    = 1'b0;
        instr    = {OP_ADD, 1'b0, 3'd5, 3'd0, 3'd0, 17'h0};
        b3_wr_en = 1'b1;
        b3_data  = JUNK;
        @(negedge clk);
        rst_n    = 1'b1;
        b3_wr_en = 1'b0;
        for (int i = 1; i < 8; i++) begin
            drive(OP_ADD, 3'd0, 3'(i), 3'(i), 1'b1, 1'b1, 1'b0, '0);
            check("R8", $sformatf("rerun B1 reg%0d", i), b1_data, 32'h0);
            check("R8", $sformatf("rerun B2 reg%0d", i), b2_data, 32'h0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule